// File: doc/BRIEF.md
# Host Bridge Window Register Bank

This block is the 64-bit control register file of a PCI host bridge. It holds a set of address-window descriptors, one per window. Each descriptor has a base register, a mask register and a translated-base register. The bank also holds one bridge control register. Every descriptor register and the control register drive output ports continuously, so the DMA address translator reads its configuration straight from them.

Software reaches the bank through a 4 KB memory-mapped region. Registers sit in slots 64 bytes apart. Every access is a single 64-bit read or write. Each accepted request gets a registered response on the next cycle, carrying the read data and an error bit. Some slots belong to functions that live outside this block: error logging, TLB invalidation and performance monitoring. These slots either read as zero and accept writes with no effect, or they flag an error. Unassigned slot numbers always flag an error.

Top module: `hbw_regbank`

## Requirements
- R1: During and after reset, all twelve window registers (base, mask, translated base) hold zero and the control register holds 64'h0000_0021_0010_0000 (bit 20 set, bit 32 set, value 2 in bits [39:36]). rsp_valid is low.
- R2: The slot number is req_addr[11:6]. Address bits [5:0] have no effect on which register is accessed.
- R3: Slots 0–3 are the window bases, 4–7 the window masks and 8–11 the translated bases, with window n at the lowest slot of its group plus n. A write updates the matching win_*_o field (64 bits per window, window n at bits [64n+63:64n]) on the edge that accepts it. A later read returns the stored value.
- R4: Slot 12 is the control register. It is readable and writable, and its value appears on ctrl_o.
- R5: Each cycle with req_valid high gives rsp_valid high on exactly the next cycle. An idle cycle gives rsp_valid low on the next cycle. Write responses carry rsp_rdata zero.
- R6: Slots 15 and 16 read as zero with rsp_err low. A write to slot 15 completes without error and changes no register.
- R7: Slot 19 reads as zero. A write to it completes without error and changes no register.
- R8: A write to slot 16 responds with rsp_err high and changes no register.
- R9: Every other slot flags rsp_err on both reads and writes, returns rsp_rdata zero and changes no register. This covers 13, 14, 17, 18, 20, 21 and 22–63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the 4 KB region |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Access hit an unsupported slot or operation |
| rsp_rdata | output | 64 | Read data, zero for writes and errors |
| win_base_o | output | 256 | Window base registers, window n at [64n+63:64n] |
| win_mask_o | output | 256 | Window mask registers |
| win_xlat_o | output | 256 | Translated-base registers |
| ctrl_o | output | 64 | Bridge control register |

## Verification
Both the response fields and any register change caused by a write are due one rising edge after the request is presented. Nothing in the block takes longer than that edge. The bench therefore drives each request at a falling edge and samples rsp_valid, rsp_err, rsp_rdata and all four register outputs at the following falling edge. It withdraws the request at that same moment. Idle gaps are sampled one falling edge later to confirm that the strobe drops.

// File: rtl/hbw_pkg.sv
package hbw_pkg;

    // What a decoded slot does on read and on write
    typedef enum logic [2:0] {
        SK_BASE,       // window base register
        SK_MASK,       // window mask register
        SK_XLAT,       // translated-base register
        SK_CTRL,       // bridge control register
        SK_ZERO_IGN,   // reads zero, writes discarded
        SK_ZERO_WERR,  // reads zero, writes flag an error
        SK_BAD         // any access flags an error
    } slot_kind_e;

    localparam int unsigned DATA_W = 64;

    localparam logic [DATA_W-1:0] CTRL_RESET =
        (64'h1 << 20) | (64'h1 << 32) | (64'h2 << 36);

endpackage

// File: rtl/hbw_slot_decode.sv
module hbw_slot_decode
    import hbw_pkg::*;
#(
    parameter int unsigned AW     = 12,
    parameter int unsigned SHIFT  = 6,
    parameter int unsigned NWIN   = 4,
    localparam int unsigned SELW  = $clog2(NWIN)
) (
    input  logic [AW-1:0]   addr,
    output slot_kind_e      kind,
    output logic [SELW-1:0] sel
);

    localparam int unsigned IW       = AW - SHIFT;
    localparam int unsigned L_MASK   = NWIN;
    localparam int unsigned L_XLAT   = 2 * NWIN;
    localparam int unsigned L_CTRL   = 3 * NWIN;
    localparam int unsigned L_ESTAT  = L_CTRL + 3;
    localparam int unsigned L_EMASK  = L_CTRL + 4;
    localparam int unsigned L_INVALL = L_CTRL + 7;

    logic [IW-1:0] idx;
    int unsigned   iv;

    assign idx = addr[AW-1:SHIFT];

    always_comb begin
        iv   = 32'(idx);
        kind = SK_BAD;
        sel  = '0;
        if (iv < L_MASK) begin
            kind = SK_BASE;
            sel  = SELW'(iv);
        end else if (iv < L_XLAT) begin
            kind = SK_MASK;
            sel  = SELW'(iv - L_MASK);
        end else if (iv < L_CTRL) begin
            kind = SK_XLAT;
            sel  = SELW'(iv - L_XLAT);
        end else if (iv == L_CTRL) begin
            kind = SK_CTRL;
        end else if (iv == L_ESTAT || iv == L_INVALL) begin
            kind = SK_ZERO_IGN;
        end else if (iv == L_EMASK) begin
            kind = SK_ZERO_WERR;
        end
    end

endmodule

// File: rtl/hbw_regs.sv
module hbw_regs
    import hbw_pkg::*;
#(
    parameter int unsigned NWIN  = 4,
    parameter int unsigned DW    = DATA_W,
    localparam int unsigned SELW = $clog2(NWIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  slot_kind_e       kind,
    input  logic [SELW-1:0]  sel,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rd,
    output logic [NWIN*DW-1:0] base_o,
    output logic [NWIN*DW-1:0] mask_o,
    output logic [NWIN*DW-1:0] xlat_o,
    output logic [DW-1:0]    ctrl_o
);

    typedef struct packed {
        logic [NWIN-1:0][DW-1:0] base;
        logic [NWIN-1:0][DW-1:0] mask;
        logic [NWIN-1:0][DW-1:0] xlat;
        logic [DW-1:0]           ctrl;
    } bank_t;

    localparam bank_t BANK_RESET = '{
        base: '0, mask: '0, xlat: '0, ctrl: DW'(CTRL_RESET)
    };

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we) begin
            case (kind)
                SK_BASE: bank_d.base[sel] = wdata;
                SK_MASK: bank_d.mask[sel] = wdata;
                SK_XLAT: bank_d.xlat[sel] = wdata;
                SK_CTRL: bank_d.ctrl      = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= BANK_RESET;
        else        bank_q <= bank_d;
    end

    always_comb begin
        case (kind)
            SK_BASE: rd = bank_q.base[sel];
            SK_MASK: rd = bank_q.mask[sel];
            SK_XLAT: rd = bank_q.xlat[sel];
            SK_CTRL: rd = bank_q.ctrl;
            default: rd = '0;
        endcase
    end

    assign base_o = bank_q.base;
    assign mask_o = bank_q.mask;
    assign xlat_o = bank_q.xlat;
    assign ctrl_o = bank_q.ctrl;

endmodule

// File: rtl/hbw_regbank.sv
module hbw_regbank
    import hbw_pkg::*;
#(
    parameter int unsigned AW    = 12,
    parameter int unsigned SHIFT = 6,
    parameter int unsigned NWIN  = 4,
    parameter int unsigned DW    = DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [DW-1:0]      rsp_rdata,
    output logic [NWIN*DW-1:0] win_base_o,
    output logic [NWIN*DW-1:0] win_mask_o,
    output logic [NWIN*DW-1:0] win_xlat_o,
    output logic [DW-1:0]      ctrl_o
);

    localparam int unsigned SELW = $clog2(NWIN);

    typedef struct packed {
        logic          valid;
        logic          err;
        logic [DW-1:0] rdata;
    } rsp_t;

    slot_kind_e      kind;
    logic [SELW-1:0] sel;
    logic [DW-1:0]   rd;
    logic            bad;
    rsp_t            rsp_d, rsp_q;

    hbw_slot_decode #(
        .AW(AW), .SHIFT(SHIFT), .NWIN(NWIN)
    ) dec_i (
        .addr (req_addr),
        .kind (kind),
        .sel  (sel)
    );

    hbw_regs #(
        .NWIN(NWIN), .DW(DW)
    ) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (req_valid && req_write),
        .kind   (kind),
        .sel    (sel),
        .wdata  (req_wdata),
        .rd     (rd),
        .base_o (win_base_o),
        .mask_o (win_mask_o),
        .xlat_o (win_xlat_o),
        .ctrl_o (ctrl_o)
    );

    always_comb begin
        bad         = (kind == SK_BAD) || (kind == SK_ZERO_WERR && req_write);
        rsp_d.valid = req_valid;
        rsp_d.err   = req_valid && bad;
        rsp_d.rdata = (req_valid && !req_write && !bad) ? rd : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;

endmodule

// File: rtl/hbw_regbank_chk.sv
module hbw_regbank_chk #(
    parameter int unsigned AW   = 12,
    parameter int unsigned NWIN = 4,
    parameter int unsigned DW   = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [AW-1:0]      req_addr,
    input logic               rsp_valid,
    input logic               rsp_err,
    input logic [DW-1:0]      rsp_rdata,
    input logic [NWIN*DW-1:0] win_base_o,
    input logic [NWIN*DW-1:0] win_mask_o,
    input logic [NWIN*DW-1:0] win_xlat_o,
    input logic [DW-1:0]      ctrl_o
);

    p_rsp_follows_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_write_no_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == '0));

    p_err_zero_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));

    // a rejected access (R8 and R9) leaves every register as it was
    p_err_keeps_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> ($stable(win_base_o) && $stable(win_mask_o) &&
                     $stable(win_xlat_o) && $stable(ctrl_o)));

    p_regs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> ($stable(win_base_o) && $stable(win_mask_o) &&
                                       $stable(win_xlat_o) && $stable(ctrl_o)));

endmodule

bind hbw_regbank hbw_regbank_chk #(.AW(AW), .NWIN(NWIN), .DW(DW)) chk_i (.*);

// File: tb/hbw_regbank_tb_top.sv
module hbw_regbank_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [11:0]  req_addr = '0;
    logic [63:0]  req_wdata = '0;
    logic         rsp_valid;
    logic         rsp_err;
    logic [63:0]  rsp_rdata;
    logic [255:0] win_base_o, win_mask_o, win_xlat_o;
    logic [63:0]  ctrl_o;

    int checks = 0;
    int errors = 0;

    logic [63:0] m_base [4];
    logic [63:0] m_mask [4];
    logic [63:0] m_xlat [4];
    logic [63:0] m_ctrl;

    localparam logic [63:0] CTRL_RST = 64'h0000_0021_0010_0000;

    always #2.5 clk = ~clk;

    hbw_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .win_base_o(win_base_o),
        .win_mask_o(win_mask_o), .win_xlat_o(win_xlat_o), .ctrl_o(ctrl_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit exp_err(input int idx, input bit wr);
        if (idx <= 12 || idx == 15 || idx == 19) return 1'b0;
        if (idx == 16) return wr;
        return 1'b1;
    endfunction

    function automatic logic [63:0] exp_rdata(input int idx, input bit wr);
        if (wr || exp_err(idx, wr)) return '0;
        if (idx < 4)   return m_base[idx];
        if (idx < 8)   return m_mask[idx-4];
        if (idx < 12)  return m_xlat[idx-8];
        if (idx == 12) return m_ctrl;
        return '0;
    endfunction

    function automatic string tag_of(input int idx, input bit wr);
        if (idx < 12)  return "R3";
        if (idx == 12) return "R4";
        if (idx == 16 && wr) return "R8";
        if (idx == 15 || idx == 16) return "R6";
        if (idx == 19) return "R7";
        return "R9";
    endfunction

    task automatic model_write(input int idx, input logic [63:0] d);
        if (idx < 4)       m_base[idx]   = d;
        else if (idx < 8)  m_mask[idx-4] = d;
        else if (idx < 12) m_xlat[idx-8] = d;
        else if (idx == 12) m_ctrl       = d;
    endtask

    task automatic check_outputs(input string tag);
        for (int i = 0; i < 4; i++) begin
            chk(win_base_o[i*64 +: 64] === m_base[i], tag, win_base_o[i*64 +: 64], m_base[i]);
            chk(win_mask_o[i*64 +: 64] === m_mask[i], tag, win_mask_o[i*64 +: 64], m_mask[i]);
            chk(win_xlat_o[i*64 +: 64] === m_xlat[i], tag, win_xlat_o[i*64 +: 64], m_xlat[i]);
        end
        chk(ctrl_o === m_ctrl, tag, ctrl_o, m_ctrl);
    endtask

    // called at a falling edge; returns at the falling edge where the response is due
    task automatic access(input bit wr, input logic [11:0] a, input logic [63:0] d);
        int          idx;
        bit          e;
        logic [63:0] x;
        string       t;
        idx = int'(a[11:6]);
        e   = exp_err(idx, wr);
        x   = exp_rdata(idx, wr);
        t   = tag_of(idx, wr);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (wr && !e) model_write(idx, d);
        chk(rsp_valid === 1'b1, "R5", 64'(rsp_valid), 64'd1);
        chk(rsp_err === e, t, 64'(rsp_err), 64'(e));
        chk(rsp_rdata === x, t, rsp_rdata, x);
        check_outputs(t);
    endtask

    task automatic idle_check;
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R5", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < 4; i++) begin
            m_base[i] = '0; m_mask[i] = '0; m_xlat[i] = '0;
        end
        m_ctrl = CTRL_RST;
        repeat (3) @(negedge clk);
        // R1: reset values
        check_outputs("R1");
        chk(rsp_valid === 1'b0, "R1", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R1");
        access(1'b0, 12'(12 << 6), '0);

        // R2: low address bits do not change the slot
        access(1'b1, 12'h06A, 64'hDEAD_BEEF_0123_4567);
        access(1'b0, 12'h07F, '0);
        chk(rsp_rdata === 64'hDEAD_BEEF_0123_4567, "R2", rsp_rdata, 64'hDEAD_BEEF_0123_4567);

        // R3: every window register
        for (int s = 0; s < 12; s++)
            access(1'b1, 12'(s << 6), {32'(s + 1), 32'hA5A5_0000 + 32'(s)});
        for (int s = 0; s < 12; s++) access(1'b0, 12'(s << 6), '0);

        // R4: control register
        access(1'b1, 12'(12 << 6), 64'h0123_4567_89AB_CDEF);
        access(1'b0, 12'(12 << 6) | 12'h3, '0);

        // R6, R7, R8: zero-reading slots
        access(1'b1, 12'(15 << 6), '1);
        access(1'b0, 12'(15 << 6), '0);
        access(1'b0, 12'(16 << 6), '0);
        access(1'b1, 12'(16 << 6), '1);
        access(1'b1, 12'(19 << 6), '1);
        access(1'b0, 12'(19 << 6), '0);

        // R9: unimplemented slots, both directions
        access(1'b1, 12'(13 << 6), '1);
        access(1'b0, 12'(18 << 6), '0);
        access(1'b1, 12'(21 << 6), '1);
        access(1'b0, 12'(63 << 6) | 12'h3F, '0);

        // R5: idle gap after traffic
        idle_check();
        idle_check();

        // random mix
        for (int n = 0; n < 1500; n++) begin
            int          idx;
            bit          wr;
            logic [63:0] d;
            idx = ($urandom % 4 == 0) ? int'($urandom % 64) : int'($urandom % 22);
            wr  = 1'($urandom % 2);
            d   = {$urandom, $urandom};
            access(wr, 12'(idx << 6) | 12'($urandom % 64), d);
            if ($urandom % 8 == 0) idle_check();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule